// File: doc/BRIEF.md
# Serial ADC Output Responder

This block stands in for the output side of a 10-bit, single-channel serial analog-to-digital converter. A test harness or an FPGA loopback connects a serial master to it, and the master reads back a known word exactly as it would read a real converter. The responder takes the chip-select, serial clock and a parallel sample word. It drives a data bit, an output-enable for an external tri-state pad, and a status count. Both serial pins are brought into the system clock domain through synchronizers, and all frame logic runs on the system clock.

A frame begins when chip-select goes low, and the sample word is captured at that moment. The data line stays disabled through the first two clock pulses. After that the responder drives a zero null bit, then the word from its most significant bit down. It then replays the word from bit 1 back up to bit 9, and after that drives zeros. Bits change only after serial clock falling edges. The position in the frame comes from counted rising edges, so a master whose clock idles low and one whose clock idles high read the same bits at their rising edges.

The frame controller has six states. IDLE waits for a frame. LEAD holds the line disabled for the first two pulses. NULLB drives the null bit. MSBF shifts the word out MSB first. LSBF replays it LSB first. TAIL drives zeros. The transitions are: IDLE to LEAD on a chip-select fall. LEAD to NULLB on the falling edge after the second rising edge. NULLB to MSBF on the next falling edge. MSBF to LSBF after bit 0 has been sent. LSBF to TAIL after the replayed bit 9. Any state returns to IDLE when chip-select goes high.

Top module: `serial_adc_responder`

## Requirements
- R1: After reset, sdo_oe is 0, sdo is 0 and fall_count is 0.
- R2: While cs_n is high, sdo_oe is 0 and fall_count is 0. Raising cs_n part way through a frame abandons it, and the next frame starts again from its first pulse.
- R3: With the serial clock idling low, sdo_oe is 0 at the 1st and 2nd rising edges of the frame.
- R4: At rising edge 3, sdo_oe is 1 and sdo is 0 (the null bit).
- R5: At rising edges 4 to 13, sdo carries word bit (13 - r) for rising edge r, so bit 9 comes first and bit 0 comes last.
- R6: At rising edges 14 to 22, sdo carries word bit (r - 13), so bit 1 comes first and bit 9 comes last.
- R7: From rising edge 23 until cs_n rises, sdo_oe stays 1 and sdo is 0.
- R8: sdo and sdo_oe do not change across a rising serial clock edge. While chip-select is active, they change only after a falling edge.
- R9: The word is captured when cs_n falls. Later changes on sample_in have no effect on the bits of that frame.
- R10: When the clock idles high at the chip-select fall, the values seen at each rising edge match R3 to R7. The first falling edge then leaves the line disabled.
- R11: fall_count gives the number of serial clock falling edges in the current frame. It saturates at 31 and clears when cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip-select from the master |
| sclk | input | 1 | Serial clock from the master |
| sample_in | input | 10 | Word to be sent, captured at chip-select fall |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the external data pad |
| fall_count | output | 5 | Falling edges counted in the current frame, saturating |

## Verification
The hardest situations to reach from the ports are the two clock polarities and the long tail. With an idle-high clock, an extra falling edge arrives before the first rising edge. Reaching the zero tail and the count saturation needs frames of more than 22 and more than 31 pulses. The stimulus table alternates the two clock idle levels, uses frame lengths of 16 to 40 pulses, and in some rows scrambles sample_in after the first pulse. It samples the line just before every rising edge, as a master would, and again just after that edge. A directed test then cuts a frame short and checks that the following frame starts cleanly.

// File: rtl/sadc_resp_pkg.sv
package sadc_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_NULLB = 3'd2,
        ST_MSBF  = 3'd3,
        ST_LSBF  = 3'd4,
        ST_TAIL  = 3'd5
    } frame_st_e;

endpackage

// File: rtl/sadc_pin_sync.sv
module sadc_pin_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    for (genvar b = 0; b < W; b++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
                prev_q  <= RST_VAL[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[b]  = chain_q[STAGES-1];
        assign rise_o[b] = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[b] = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/sadc_edge_tally.sv
module sadc_edge_tally #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sadc_frame_fsm.sv
module sadc_frame_fsm
    import sadc_resp_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 5,
    parameter int LEAD_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active_i,
    input  logic              frame_start_i,
    input  logic              sclk_fall_i,
    input  logic [CNT_W-1:0]  pos_i,
    input  logic [DATA_W-1:0] word_i,
    output frame_st_e         state_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MSB_END = LEAD_N + DATA_W;
    localparam int LSB_END = LEAD_N + 2 * DATA_W - 1;

    frame_st_e        state_q;
    frame_st_e        state_d;
    logic [IDX_W-1:0] idx;
    int               pos_int;

    assign pos_int = int'(pos_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_active_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (frame_start_i) state_d = ST_LEAD;
                ST_LEAD:  if (sclk_fall_i && pos_int >= LEAD_N) state_d = ST_NULLB;
                ST_NULLB: if (sclk_fall_i && pos_int > LEAD_N) state_d = ST_MSBF;
                ST_MSBF:  if (sclk_fall_i && pos_int > MSB_END) state_d = ST_LSBF;
                ST_LSBF:  if (sclk_fall_i && pos_int > LSB_END) state_d = ST_TAIL;
                ST_TAIL:  state_d = ST_TAIL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit index for the state being entered
    always_comb begin
        idx = '0;
        if (state_d == ST_MSBF && pos_int <= MSB_END) begin
            idx = IDX_W'(MSB_END - pos_int);
        end else if (state_d == ST_LSBF && pos_int > MSB_END) begin
            idx = IDX_W'(pos_int - MSB_END);
        end
    end

    // output register: updates on falling edges only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
        end else if (!cs_active_i) begin
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
        end else if (sclk_fall_i) begin
            unique case (state_d)
                ST_IDLE, ST_LEAD: begin
                    sdo_o    <= 1'b0;
                    sdo_oe_o <= 1'b0;
                end
                ST_MSBF, ST_LSBF: begin
                    sdo_o    <= word_i[idx];
                    sdo_oe_o <= 1'b1;
                end
                default: begin
                    sdo_o    <= 1'b0;
                    sdo_oe_o <= 1'b1;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/serial_adc_responder.sv
module serial_adc_responder
    import sadc_resp_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CNT_W-1:0]  fall_count
);

    localparam int LEAD_N = 2;
    localparam int PIN_W  = 2;
    localparam int CS_B   = 0;
    localparam int SCK_B  = 1;

    logic [PIN_W-1:0]  pin_lvl;
    logic [PIN_W-1:0]  pin_rise;
    logic [PIN_W-1:0]  pin_fall;
    logic              cs_active;
    logic              frame_start;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [CNT_W-1:0]  rise_pos;
    logic [DATA_W-1:0] word_q;
    frame_st_e         state;

    sadc_pin_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (PIN_W),
        .RST_VAL (2'b01)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sclk, cs_n}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign cs_active   = ~pin_lvl[CS_B];
    assign frame_start = pin_fall[CS_B];
    assign sclk_rise   = pin_rise[SCK_B] & cs_active;
    assign sclk_fall   = pin_fall[SCK_B] & cs_active;

    sadc_edge_tally #(.W(CNT_W)) rise_tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (~cs_active),
        .inc_i (sclk_rise),
        .cnt_o (rise_pos)
    );

    sadc_edge_tally #(.W(CNT_W)) fall_tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (~cs_active),
        .inc_i (sclk_fall),
        .cnt_o (fall_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           word_q <= '0;
        else if (frame_start) word_q <= sample_in;
    end

    sadc_frame_fsm #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .LEAD_N (LEAD_N)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_active_i   (cs_active),
        .frame_start_i (frame_start),
        .sclk_fall_i   (sclk_fall),
        .pos_i         (rise_pos),
        .word_i        (word_q),
        .state_o       (state),
        .sdo_o         (sdo),
        .sdo_oe_o      (sdo_oe)
    );

endmodule

// File: rtl/sadc_resp_chk.sv
module sadc_resp_chk
    import sadc_resp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_active,
    input logic             sclk_fall,
    input frame_st_e        state,
    input logic             sdo,
    input logic             sdo_oe,
    input logic [CNT_W-1:0] fall_count
);

    // R2
    cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !sdo_oe);

    // R8
    hold_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !sclk_fall) |=> ($stable(sdo) && $stable(sdo_oe)));

    // R3
    lead_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> !sdo_oe);

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (sdo_oe && !sdo));

    // R11
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (fall_count == '0));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && sclk_fall && fall_count != {CNT_W{1'b1}})
        |=> (fall_count == $past(fall_count) + 1'b1));

endmodule

bind serial_adc_responder sadc_resp_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .sclk_fall  (sclk_fall),
    .state      (state),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .fall_count (fall_count)
);

// File: tb/serial_adc_responder_tb.sv
module serial_adc_responder_tb_top;

    localparam int HALF = 8;
    localparam int NV   = 6;

    localparam logic [9:0] V_WORD   [NV] = '{10'h2B5, 10'h3FF, 10'h000, 10'h155, 10'h201, 10'h0F3};
    localparam bit         V_IDLEHI [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int         V_PULSES [NV] = '{24, 24, 26, 40, 16, 25};
    localparam bit         V_SCR    [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [9:0] sample_in = '0;
    logic       sdo;
    logic       sdo_oe;
    logic [4:0] fall_count;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    serial_adc_responder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sample_in  (sample_in),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .fall_count (fall_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    // expected line state seen at rising edge r of a frame
    task automatic expect_at(input logic [9:0] w, input int r, output bit eoe, output bit ebit);
        eoe  = (r >= 3);
        ebit = 1'b0;
        if (r >= 4 && r <= 13)      ebit = w[13 - r];
        else if (r >= 14 && r <= 22) ebit = w[r - 13];
    endtask

    function automatic string tag_for(input int r, input bit idle_hi, input bit scr);
        if (idle_hi && r >= 1) return "R10";
        if (scr && r >= 4 && r <= 22) return "R9";
        if (r <= 2)  return "R3";
        if (r == 3)  return "R4";
        if (r <= 13) return "R5";
        if (r <= 22) return "R6";
        return "R7";
    endfunction

    task automatic run_frame(input logic [9:0] w, input bit idle_hi, input int n, input bit scr);
        bit    eoe;
        bit    ebit;
        logic  s_pre;
        logic  oe_pre;
        string tg;
        sclk      = idle_hi;
        sample_in = w;
        wait_half();
        check(!sdo_oe, "R2", int'(sdo_oe), 0);
        cs_n = 1'b0;
        wait_half();
        for (int r = 1; r <= n; r++) begin
            if (idle_hi) begin
                sclk = 1'b0;
                wait_half();
            end
            expect_at(w, r, eoe, ebit);
            tg = tag_for(r, idle_hi, scr);
            check(sdo_oe == eoe, tg, int'(sdo_oe), int'(eoe));
            if (eoe) check(sdo == ebit, tg, int'(sdo), int'(ebit));
            s_pre  = sdo;
            oe_pre = sdo_oe;
            sclk = 1'b1;
            wait_half();
            check(sdo == s_pre && sdo_oe == oe_pre, "R8", int'({sdo_oe, sdo}), int'({oe_pre, s_pre}));
            if (!idle_hi) begin
                sclk = 1'b0;
                wait_half();
            end
            if (scr && r == 1) sample_in = ~w;
        end
        check(int'(fall_count) == ((n > 31) ? 31 : n), "R11", int'(fall_count), (n > 31) ? 31 : n);
        cs_n = 1'b1;
        wait_half();
        check(!sdo_oe, "R2", int'(sdo_oe), 0);
        check(fall_count == 5'd0, "R11", int'(fall_count), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(!sdo_oe && !sdo, "R1", int'({sdo_oe, sdo}), 0);
        check(fall_count == 5'd0, "R1", int'(fall_count), 0);
        rst_n = 1'b1;
        wait_half();
        check(!sdo_oe && fall_count == 5'd0, "R1", int'(fall_count), 0);

        for (int v = 0; v < NV; v++) begin
            run_frame(V_WORD[v], V_IDLEHI[v], V_PULSES[v], V_SCR[v]);
        end

        // R2: abort mid-frame with the clock idling low, then a clean frame
        run_frame(10'h1C6, 1'b0, 8, 1'b0);
        run_frame(10'h239, 1'b0, 23, 1'b0);
        // R2: abort mid-frame with the clock idling high, then a clean frame
        run_frame(10'h0AA, 1'b1, 5, 1'b0);
        run_frame(10'h36C, 1'b1, 23, 1'b0);

        // R9: sample_in changing while CS is high is picked up by the next frame
        sample_in = 10'h111;
        wait_half();
        run_frame(10'h2EE, 1'b0, 14, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule